// File: doc/BRIEF.md
# Error Report Double-Buffered Readout

This block keeps one error report, made of an error class code, an error position and a syndrome value. It hands that report to two readers that run independently of each other. The debug reader pulls the report out one bit at a time. The core reader can take the whole report in parallel or shift it out serially.

When a new report is written into the message register, each reader copies it into its own staging register on the following clock edge. A reader then takes a snapshot of its staging register into its own output shift register when it asks for one.

The staging write and the snapshot read must not fall on the same edge. Each reader therefore has a small state machine with two states:
- `RD_IDLE`: the normal state.
- `RD_HOLD`: a snapshot request has been postponed.

The state machine has these transitions:
- `RD_IDLE` → `RD_HOLD`: a request arrives in the same cycle as a staging write.
- `RD_HOLD` → `RD_HOLD`: a staging write is still occurring.
- `RD_HOLD` → `RD_IDLE`: the first cycle with no staging write, in which the snapshot is taken.
- `RD_IDLE` → `RD_IDLE`: every other case. If a request arrives with no staging write, the snapshot is taken at once.

Top module: `err_report_readout`

## Requirements
- R1: After reset, both staging registers, both shift registers and both pending-report flags are zero, so `dbg_tdo`, `usr_sdo` and `usr_data` read 0.
- R2: A cycle with `msg_valid` high stores `{msg_syn, msg_loc, msg_type}` into the message register at that edge. Both staging registers copy the message register at the next edge.
- R3: A snapshot request that does not coincide with a staging write loads the shift register from the staging register at that edge. The result is visible on `usr_data` or `dbg_tdo` after that edge.
- R4: A snapshot request in the cycle of a staging write is postponed (`RD_HOLD`). It completes at the first later edge with no staging write, and it takes the newly written report.
- R5: Each shift-enable cycle moves the shift register one place toward bit 0 and fills the top bit with 0. The serial output is bit 0, so the output order is:
  - type bits from bit 0 upward,
  - then the position bits,
  - then the syndrome bits.
- R6: When a snapshot and a shift fall on the same edge, the snapshot wins and no shift is applied.
- R7: A reader's pending-report flag goes to 1 on every staging write and returns to 0 when that reader's snapshot completes.
- R8: A snapshot or shift on one reader leaves the other reader's flag and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Strobe that stores a new report |
| msg_type | input | TYPE_W | Error class code |
| msg_loc | input | LOC_W | Error position |
| msg_syn | input | SYN_W | Syndrome value |
| dbg_capture | input | 1 | Debug reader snapshot request |
| dbg_shift | input | 1 | Debug reader shift enable |
| dbg_tdo | output | 1 | Debug serial output (shift register bit 0) |
| dbg_new | output | 1 | Debug pending-report flag |
| usr_capture | input | 1 | Core reader snapshot request |
| usr_shift | input | 1 | Core reader shift enable |
| usr_data | output | TYPE_W+LOC_W+SYN_W | Core reader shift register contents |
| usr_sdo | output | 1 | Core serial output (bit 0 of `usr_data`) |
| usr_new | output | 1 | Core pending-report flag |

## Verification
If the message register or the staging logic is wrong, the error appears on `usr_data` one edge after the next snapshot. On the debug side it appears bit by bit as the report is shifted out. If the hold state machine is wrong, `usr_data` shows the stale report one edge too late or too early. In the same way, `usr_new` stays set or drops at the wrong edge. A broken shift direction or fill value shows on the serial outputs within the first few shift cycles.

// File: rtl/err_rpt_pkg.sv
package err_rpt_pkg;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_HOLD = 1'b1
    } rd_state_e;

endpackage

// File: rtl/err_msg_store.sv
module err_msg_store #(
    parameter int TYPE_W = 4,
    parameter int LOC_W  = 16,
    parameter int SYN_W  = 32,
    localparam int REC_W = TYPE_W + LOC_W + SYN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [TYPE_W-1:0] msg_type,
    input  logic [LOC_W-1:0]  msg_loc,
    input  logic [SYN_W-1:0]  msg_syn,
    output logic [REC_W-1:0]  rec_q,
    output logic              ld_pulse
);

    // Record layout: type in the low bits, then position, then syndrome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q    <= '0;
            ld_pulse <= 1'b0;
        end else begin
            ld_pulse <= msg_valid;
            if (msg_valid) begin
                rec_q <= {msg_syn, msg_loc, msg_type};
            end
        end
    end

endmodule

// File: rtl/err_reader.sv
module err_reader
    import err_rpt_pkg::*;
#(
    parameter int REC_W = 52,
    parameter int OUT_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_we,
    input  logic [REC_W-1:0] rec_i,
    input  logic             cap_req,
    input  logic             shift_en,
    output logic [OUT_W-1:0] rd_q,
    output logic             new_o,
    output logic             hold_o
);

    rd_state_e        st_q, st_d;
    logic             cap_do;
    logic [REC_W-1:0] upd_q;
    logic [REC_W-1:0] sh_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (cap_req && upd_we) st_d = RD_HOLD;
            RD_HOLD: if (!upd_we)           st_d = RD_IDLE;
            default:                        st_d = RD_IDLE;
        endcase
    end

    // Outputs of the machine.
    always_comb begin
        cap_do = 1'b0;
        hold_o = 1'b0;
        unique case (st_q)
            RD_IDLE: cap_do = cap_req && !upd_we;
            RD_HOLD: begin
                cap_do = !upd_we;
                hold_o = 1'b1;
            end
            default: cap_do = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q <= '0;
            sh_q  <= '0;
            new_o <= 1'b0;
        end else begin
            if (upd_we) begin
                upd_q <= rec_i;
            end
            if (cap_do) begin
                sh_q <= upd_q;
            end else if (shift_en) begin
                sh_q <= {1'b0, sh_q[REC_W-1:1]};
            end
            if (upd_we) begin
                new_o <= 1'b1;
            end else if (cap_do) begin
                new_o <= 1'b0;
            end
        end
    end

    generate
        if (OUT_W == 1) begin : g_serial
            assign rd_q = sh_q[0];
        end else begin : g_parallel
            assign rd_q = sh_q;
        end
    endgenerate

endmodule

// File: rtl/err_report_readout.sv
module err_report_readout #(
    parameter int TYPE_W = 4,
    parameter int LOC_W  = 16,
    parameter int SYN_W  = 32,
    localparam int REC_W = TYPE_W + LOC_W + SYN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [TYPE_W-1:0] msg_type,
    input  logic [LOC_W-1:0]  msg_loc,
    input  logic [SYN_W-1:0]  msg_syn,
    input  logic              dbg_capture,
    input  logic              dbg_shift,
    output logic              dbg_tdo,
    output logic              dbg_new,
    input  logic              usr_capture,
    input  logic              usr_shift,
    output logic [REC_W-1:0]  usr_data,
    output logic              usr_sdo,
    output logic              usr_new
);

    logic [REC_W-1:0] rec_q;
    logic             ld_pulse;
    logic             dbg_hold;
    logic             usr_hold;

    err_msg_store #(
        .TYPE_W(TYPE_W), .LOC_W(LOC_W), .SYN_W(SYN_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid),
        .msg_type(msg_type), .msg_loc(msg_loc), .msg_syn(msg_syn),
        .rec_q(rec_q), .ld_pulse(ld_pulse)
    );

    err_reader #(.REC_W(REC_W), .OUT_W(1)) u_dbg (
        .clk(clk), .rst_n(rst_n), .upd_we(ld_pulse), .rec_i(rec_q),
        .cap_req(dbg_capture), .shift_en(dbg_shift),
        .rd_q(dbg_tdo), .new_o(dbg_new), .hold_o(dbg_hold)
    );

    err_reader #(.REC_W(REC_W), .OUT_W(REC_W)) u_usr (
        .clk(clk), .rst_n(rst_n), .upd_we(ld_pulse), .rec_i(rec_q),
        .cap_req(usr_capture), .shift_en(usr_shift),
        .rd_q(usr_data), .new_o(usr_new), .hold_o(usr_hold)
    );

    assign usr_sdo = usr_data[0];

endmodule

// File: rtl/err_report_readout_chk.sv
module err_report_readout_chk #(
    parameter int REC_W = 52
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_pulse,
    input logic [REC_W-1:0] rec_q,
    input logic             dbg_capture,
    input logic             dbg_hold,
    input logic             dbg_new,
    input logic             usr_capture,
    input logic             usr_shift,
    input logic             usr_hold,
    input logic [REC_W-1:0] usr_data,
    input logic             usr_new
);

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pulse |=> (dbg_new && usr_new));

    p_snapshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_capture && !ld_pulse) |=> (usr_data == $past(rec_q)));

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_capture && !ld_pulse) |=> !usr_new);

    p_postpone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pulse && usr_capture) |=> (usr_hold && usr_new));

    p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_shift && !usr_capture && !usr_hold) |=> (usr_data == ($past(usr_data) >> 1)));

    p_indep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_capture && !dbg_hold && !ld_pulse) |=> (dbg_new == $past(dbg_new)));

endmodule

bind err_report_readout err_report_readout_chk #(.REC_W(REC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_pulse(ld_pulse), .rec_q(rec_q),
    .dbg_capture(dbg_capture), .dbg_hold(dbg_hold), .dbg_new(dbg_new),
    .usr_capture(usr_capture), .usr_shift(usr_shift), .usr_hold(usr_hold),
    .usr_data(usr_data), .usr_new(usr_new)
);

// File: tb/err_report_readout_tb.sv
module err_report_readout_tb;

    localparam int TW = 4;
    localparam int LW = 16;
    localparam int SW = 32;
    localparam int RW = TW + LW + SW;

    // Each entry: {syndrome, position, type}
    localparam logic [RW-1:0] VEC [0:3] = '{
        {32'hDEADBEEF, 16'h1234, 4'h5},
        {32'h00000001, 16'h8000, 4'hF},
        {32'hA5A55A5A, 16'h0F0F, 4'h1},
        {32'h80000000, 16'h0001, 4'h8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msg_valid = 1'b0;
    logic [TW-1:0] msg_type = '0;
    logic [LW-1:0] msg_loc = '0;
    logic [SW-1:0] msg_syn = '0;
    logic          dbg_capture = 1'b0, dbg_shift = 1'b0;
    logic          usr_capture = 1'b0, usr_shift = 1'b0;
    logic          dbg_tdo, dbg_new, usr_sdo, usr_new;
    logic [RW-1:0] usr_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    err_report_readout u_dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid),
        .msg_type(msg_type), .msg_loc(msg_loc), .msg_syn(msg_syn),
        .dbg_capture(dbg_capture), .dbg_shift(dbg_shift),
        .dbg_tdo(dbg_tdo), .dbg_new(dbg_new),
        .usr_capture(usr_capture), .usr_shift(usr_shift),
        .usr_data(usr_data), .usr_sdo(usr_sdo), .usr_new(usr_new)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [RW-1:0] act, logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [RW-1:0] r);
        msg_type  = r[TW-1:0];
        msg_loc   = r[TW+LW-1:TW];
        msg_syn   = r[RW-1:TW+LW];
        msg_valid = 1'b1;
        step();
        msg_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 reset state
        check("R1 usr_data", usr_data, '0);
        check("R1 dbg_tdo", RW'(dbg_tdo), '0);
        check("R1 flags", RW'({dbg_new, usr_new}), '0);
        rst_n = 1'b1;
        step();

        // Vector walk: R2, R3, R5, R7
        for (int v = 0; v < 4; v++) begin
            load(VEC[v]);
            step();
            check("R7 flags set", RW'({dbg_new, usr_new}), RW'(2'b11));
            usr_capture = 1'b1;
            dbg_capture = 1'b1;
            step();
            usr_capture = 1'b0;
            dbg_capture = 1'b0;
            check("R2 R3 usr_data", usr_data, VEC[v]);
            check("R7 flags clear", RW'({dbg_new, usr_new}), '0);
            dbg_shift = 1'b1;
            for (int b = 0; b < RW; b++) begin
                check($sformatf("R5 dbg bit %0d", b), RW'(dbg_tdo), RW'(VEC[v][b]));
                step();
            end
            dbg_shift = 1'b0;
            check("R5 zero fill", RW'(dbg_tdo), '0);
        end

        // R5 core serial order and zero fill
        usr_shift = 1'b1;
        step();
        step();
        usr_shift = 1'b0;
        check("R5 usr shift by two", usr_data, VEC[3] >> 2);
        check("R5 usr_sdo", RW'(usr_sdo), RW'(VEC[3][2]));

        // R4 postponed snapshot
        load(VEC[0]);
        usr_capture = 1'b1;
        step();
        usr_capture = 1'b0;
        check("R4 not yet taken", usr_data, VEC[3] >> 2);
        check("R4 flag still set", RW'(usr_new), RW'(1'b1));
        step();
        check("R4 taken new report", usr_data, VEC[0]);
        check("R4 flag clear", RW'(usr_new), '0);

        // R8 independence: debug untouched by core snapshot
        check("R8 dbg flag kept", RW'(dbg_new), RW'(1'b1));
        dbg_capture = 1'b1;
        step();
        dbg_capture = 1'b0;
        check("R8 dbg own snapshot", RW'(dbg_tdo), RW'(VEC[0][0]));
        check("R8 usr_data unchanged", usr_data, VEC[0]);

        // R6 snapshot beats shift
        load(VEC[1]);
        step();
        usr_capture = 1'b1;
        usr_shift   = 1'b1;
        step();
        usr_capture = 1'b0;
        usr_shift   = 1'b0;
        check("R6 snapshot priority", usr_data, VEC[1]);

        // R3 snapshot while idle with no new report keeps contents
        usr_capture = 1'b1;
        step();
        usr_capture = 1'b0;
        check("R3 repeat snapshot", usr_data, VEC[1]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule